// File: doc/BRIEF.md
# Six-State Hardwired Instruction Sequencer

This block is the control unit of a small bus-based accumulator machine. A ring of six timing states repeats for every instruction. The first three states fetch the instruction word, and the last three execute it. In each state the block decodes the current state together with the 4-bit opcode held in the instruction register. From these it drives a 12-bit control word of bus-enable, register-load and ALU-mode lines to the datapath. The datapath, the program counter and the memory live outside the block.

The ring advances on the falling clock edge. This lets the control lines settle half a cycle before the datapath registers load on the rising edge. An execute state that an instruction does not need stays in the ring and emits the idle word. A halt opcode stops the ring and leaves every line idle until clear is asserted. The control word bits are numbered from 11 down to 0, in this order:

- 11: PC count
- 10: PC bus enable
- 9: MAR load (low)
- 8: RAM bus enable (low)
- 7: IR load (low)
- 6: IR operand bus enable (low)
- 5: accumulator load (low)
- 4: accumulator bus enable
- 3: subtract
- 2: ALU bus enable
- 1: B load (low)
- 0: output-register load (low)

Top module: `ring_sequencer`

## Requirements
- R1: While `clr` is high, `state` is 6'b000001, `halted` is 0 and `ctrl` is the idle word 12'h3E3. In the idle word all active-low lines (bits 9, 8, 7, 6, 5, 1, 0) are 1 and all active-high lines are 0.
- R2: When not halted, `state` is one-hot, with bit k meaning step T(k+1). It moves one step on each falling edge of `clk`, from T1 through T6 and then back to T1.
- R3: For every opcode, `ctrl` is 12'h5E3 in T1 (PC drives the bus, MAR loads), 12'hBE3 in T2 (PC counts) and 12'h263 in T3 (RAM drives the bus, IR loads).
- R4: For opcode 4'b0000 (load accumulator), `ctrl` is 12'h1A3 in T4, 12'h2C3 in T5 and idle in T6.
- R5: For opcode 4'b0001 (add), `ctrl` is 12'h1A3 in T4, 12'h2E1 in T5 and 12'h3C7 in T6.
- R6: For opcode 4'b0010 (subtract), `ctrl` matches the add case except in T6, where it is 12'h3CF with the subtract line (bit 3) set.
- R7: For opcode 4'b1110 (output), `ctrl` is 12'h3F2 in T4 and idle in T5 and T6.
- R8: For opcode 4'b1111 (halt), `ctrl` is idle in T4. On the falling edge that ends T4, `halted` becomes 1 and `state` becomes 0. Both stay that way, with `ctrl` idle and the opcode ignored, until `clr` is asserted.
- R9: Any other opcode gives the idle word in T4, T5 and T6, and the ring keeps running.
- R10: In every state, at most one bus source is enabled. The bus sources are PC, RAM, IR operand, accumulator and ALU.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the ring advances on the falling edge |
| clr | input | 1 | Asynchronous clear, active high |
| opcode | input | 4 | Opcode field of the instruction register |
| ctrl | output | 12 | Control word, bit order as listed above |
| state | output | 6 | One-hot timing state T1..T6; all zero when halted |
| halted | output | 1 | High after a halt instruction, until clear |

## Verification
On every falling edge, the checker confirms four things. The state vector stays one-hot while running. T6 wraps to T1. A halt decoded in T4 is followed by a sticky halt with all lines idle. No two bus sources are enabled together. The exact control word for each opcode and step, the idle word during clear, the no-op execute steps of undefined opcodes and the restart after clear are shown only by the bench. It replays instruction sequences and compares each step with the expected word.

// File: rtl/ring_sequencer.sv
module ring_sequencer #(
  parameter int OPW = 4,
  parameter int CW  = 12,
  parameter int NS  = 6
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [OPW-1:0] opcode,
  output logic [CW-1:0]  ctrl,
  output logic [NS-1:0]  state,
  output logic           halted
);
  localparam logic [OPW-1:0] OP_LDA = 4'b0000;
  localparam logic [OPW-1:0] OP_ADD = 4'b0001;
  localparam logic [OPW-1:0] OP_SUB = 4'b0010;
  localparam logic [OPW-1:0] OP_OUT = 4'b1110;
  localparam logic [OPW-1:0] OP_HLT = 4'b1111;

  localparam logic [CW-1:0] W_IDLE   = 12'h3E3;
  localparam logic [CW-1:0] W_PC_MAR = 12'h5E3;
  localparam logic [CW-1:0] W_PC_INC = 12'hBE3;
  localparam logic [CW-1:0] W_MEM_IR = 12'h263;
  localparam logic [CW-1:0] W_IR_MAR = 12'h1A3;
  localparam logic [CW-1:0] W_MEM_A  = 12'h2C3;
  localparam logic [CW-1:0] W_MEM_B  = 12'h2E1;
  localparam logic [CW-1:0] W_ALU_A  = 12'h3C7;
  localparam logic [CW-1:0] W_SUB_A  = 12'h3CF;
  localparam logic [CW-1:0] W_A_OUT  = 12'h3F2;

  logic [NS-1:0] st;
  logic          hlt;

  assign state  = st;
  assign halted = hlt;

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      st  <= {{(NS-1){1'b0}}, 1'b1};
      hlt <= 1'b0;
    end else if (!hlt) begin
      if (st[3] && opcode == OP_HLT) begin
        st  <= '0;
        hlt <= 1'b1;
      end else begin
        st <= {st[NS-2:0], st[NS-1]};
      end
    end
  end

  always_comb begin
    ctrl = W_IDLE;
    if (!clr && !hlt) begin
      unique case (1'b1)
        st[0]: ctrl = W_PC_MAR;
        st[1]: ctrl = W_PC_INC;
        st[2]: ctrl = W_MEM_IR;
        st[3]: begin
          case (opcode)
            OP_LDA, OP_ADD, OP_SUB: ctrl = W_IR_MAR;
            OP_OUT:                 ctrl = W_A_OUT;
            default:                ctrl = W_IDLE;
          endcase
        end
        st[4]: begin
          case (opcode)
            OP_LDA:         ctrl = W_MEM_A;
            OP_ADD, OP_SUB: ctrl = W_MEM_B;
            default:        ctrl = W_IDLE;
          endcase
        end
        st[5]: begin
          case (opcode)
            OP_ADD:  ctrl = W_ALU_A;
            OP_SUB:  ctrl = W_SUB_A;
            default: ctrl = W_IDLE;
          endcase
        end
        default: ctrl = W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_sequencer_chk.sv
module ring_sequencer_chk (
  input logic        clk,
  input logic        clr,
  input logic [3:0]  opcode,
  input logic [11:0] ctrl,
  input logic [5:0]  state,
  input logic        halted
);
  assert_state_onehot_R2: assert property (@(negedge clk) disable iff (clr)
    !halted |-> $countones(state) == 1);

  assert_ring_wrap_R2: assert property (@(negedge clk) disable iff (clr)
    (!halted && state[5]) |=> state[0]);

  assert_halt_entry_R8: assert property (@(negedge clk) disable iff (clr)
    (!halted && state[3] && opcode == 4'hF) |=> (halted && state == 6'b0));

  assert_halt_sticky_R8: assert property (@(negedge clk) disable iff (clr)
    halted |=> (halted && state == 6'b0 && ctrl == 12'h3E3));

  assert_one_bus_driver_R10: assert property (@(negedge clk) disable iff (clr)
    $onehot0({ctrl[10], ~ctrl[8], ~ctrl[6], ctrl[4], ctrl[2]}));
endmodule

bind ring_sequencer ring_sequencer_chk u_chk (
  .clk(clk), .clr(clr), .opcode(opcode),
  .ctrl(ctrl), .state(state), .halted(halted)
);

// File: tb/ring_sequencer_bench.sv
module ring_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [3:0]  opcode = 4'h0;
  logic [11:0] ctrl;
  logic [5:0]  state;
  logic        halted;

  int checks = 0;
  int fails  = 0;
  logic [18:0] exp_q[$];
  string       tag_q[$];

  ring_sequencer u_ring_sequencer (
    .clk(clk), .clr(clr), .opcode(opcode),
    .ctrl(ctrl), .state(state), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] exp_word(input logic [3:0] op, input int t);
    case (t)
      1: return 12'h5E3;
      2: return 12'hBE3;
      3: return 12'h263;
      4: case (op)
           4'h0, 4'h1, 4'h2: return 12'h1A3;
           4'hE:             return 12'h3F2;
           default:          return 12'h3E3;
         endcase
      5: case (op)
           4'h0:       return 12'h2C3;
           4'h1, 4'h2: return 12'h2E1;
           default:    return 12'h3E3;
         endcase
      6: case (op)
           4'h1:    return 12'h3C7;
           4'h2:    return 12'h3CF;
           default: return 12'h3E3;
         endcase
      default: return 12'h3E3;
    endcase
  endfunction

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: state/halted/ctrl actual %b/%b/%h expected %b/%b/%h",
               tag, act[18:13], act[12], act[11:0], exp[18:13], exp[12], exp[11:0]);
    end
  endtask

  task automatic push(input logic [5:0] st, input logic h, input logic [11:0] w, input string tag);
    exp_q.push_back({st, h, w});
    tag_q.push_back(tag);
  endtask

  task automatic run_instr(input logic [3:0] op, input string tag);
    opcode = op;
    for (int t = 1; t <= 6; t++)
      push(6'b1 << (t - 1), 1'b0, exp_word(op, t), (t <= 3) ? "R3 fetch" : tag);
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic run_halt();
    opcode = 4'hF;
    for (int t = 1; t <= 3; t++) push(6'b1 << (t - 1), 1'b0, exp_word(4'hF, t), "R3 fetch");
    push(6'b001000, 1'b0, 12'h3E3, "R8 halt T4");
    for (int k = 0; k < 4; k++) push(6'b0, 1'b1, 12'h3E3, "R8 halted");
    repeat (4) @(negedge clk);
    #1;
    opcode = 4'h1;
    repeat (4) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [18:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      check(tg, {state, halted, ctrl}, e);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    check("R1 reset", {state, halted, ctrl}, {6'b000001, 1'b0, 12'h3E3});
    @(negedge clk);
    #1;
    clr = 1'b0;
    run_instr(4'h0, "R4 load");
    run_instr(4'h1, "R5 add");
    run_instr(4'h1, "R5 add");
    run_instr(4'h2, "R6 sub");
    run_instr(4'hE, "R7 out");
    run_instr(4'h5, "R9 undefined");
    run_instr(4'hC, "R9 undefined");
    run_instr(4'h2, "R6 sub");
    run_halt();
    clr = 1'b1;
    #1;
    check("R1 clear after halt", {state, halted, ctrl}, {6'b000001, 1'b0, 12'h3E3});
    @(negedge clk);
    #1;
    clr = 1'b0;
    run_instr(4'h1, "R2 restart add");
    run_instr(4'h0, "R2 restart load");
    @(posedge clk);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule